// File: doc/BRIEF.md
# Tied-Strobe Serial-to-Parallel Output Latch

This block is a cycle-accurate model of a serial-in, latched parallel-out register. It has a hidden transfer stage that sits between the shift stage and the visible output latches. Each input strobe is detected as a rising edge against a fast system clock.

A rising edge on the shift strobe loads the serial bit into the shift stage. A rising edge on the storage strobe does two things: it copies the shift stage into the hidden pre-latch, and it advances the visible output chain by one place, with the old pre-latch value entering position 0. When both strobes rise in the same cycle, as they do when one pin drives both clocks, the new bit lands in the pre-latch but does not reach the outputs. The visible word therefore trails the serial stream by one strobe. A full word needs WIDTH+1 strobes to appear.

A falling edge on the active-low clear arms a clear of the shift stage and the pre-latch. The clear waits for the next shift strobe. It never touches the visible latches, and it does not disturb the bit captured by that strobe. A per-position valid mask marks which outputs hold real serial data, so a checker can see the unset state. The active-low output enable forces the data outputs to zero without changing the stored word.

Top module: `slp_latch`

## Requirements
- R1: After reset, q_o is all zero and q_valid_o is all zero. Any position whose valid bit is 0 outputs data 0.
- R2: Each combined strobe (both strobes rising in the same cycle, with no clear pending) shifts the outputs up one place: Q(n+1) takes the old Qn. Q0 takes the bit captured by the previous strobe. After the k-th strobe, Q0 holds bit k-1 and Q(k-2) holds bit 1.
- R3: After WIDTH combined strobes from reset, Q(WIDTH-1) is still invalid. After WIDTH+1 strobes, every position is valid and Q(WIDTH-1) down to Q0 hold bits 1 to WIDTH.
- R4: A falling edge on clr_ni changes neither q_o nor q_valid_o until a later storage strobe.
- R5: On the first shift strobe after a clear is armed, the shift stage and pre-latch are cleared. If the storage strobe rises in the same cycle, Q0 becomes data 0 with valid 0, and the serial bit of that strobe is still captured.
- R6: After a clear, WIDTH+1 combined strobes show the new word in full (Q(WIDTH-1) = first new bit, Q0 = last), with no residue of the old word.
- R7: While oe_ni is 1, q_o is all zero and q_valid_o is unchanged. When oe_ni returns to 0, the stored word reappears unchanged.
- R8: A strobe held high for several cycles acts exactly once, on its rising edge. Without a storage-strobe rising edge, q_valid_o does not change.
- R9: A shift-only strobe does not change the outputs. A later storage-only strobe moves the old pre-latch value into Q0 and copies the shift stage into the pre-latch. A second storage-only strobe then shows the shifted bit in Q0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial data bit |
| shift_stb_i | input | 1 | Shift strobe, acts on rising edge |
| store_stb_i | input | 1 | Storage strobe, acts on rising edge |
| clr_ni | input | 1 | Clear request, armed on falling edge |
| oe_ni | input | 1 | Output enable, active low |
| q_o | output | WIDTH | Parallel data outputs |
| q_valid_o | output | WIDTH | Per-position valid mask |

## Verification
The assertions assume that strobes and clear are synchronous to clk_i and last at least one clock in each level, so that every rising or falling edge is seen in exactly one cycle. They also assume that a clear edge never coincides with a shift-strobe edge. The stimulus drives every input on the falling clock edge and holds each strobe level for a full cycle. It issues a clear only while both strobes are low, so all of these conditions hold throughout the directed and random phases.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef struct packed {
    logic data;
    logic valid;
  } cell_t;
endpackage

// File: rtl/slp_edge_det.sv
module slp_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic idle_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= idle_i;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/slp_front.sv
module slp_front
  import slp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  data_i,
  input  logic  shift_rise_i,
  input  logic  store_rise_i,
  input  logic  clr_fall_i,
  output cell_t chain_in_o
);
  cell_t sh_q, pre_q, sh_nx, pre_nx;
  logic  pend_q, pend_nx, clr_now;

  // armed clear is consumed by the next shift strobe
  assign clr_now = pend_q & shift_rise_i;

  always_comb begin
    sh_nx = sh_q;
    if (shift_rise_i) sh_nx = '{data: data_i, valid: 1'b1};
    pre_nx = pre_q;
    if (store_rise_i) pre_nx = sh_nx;
    else if (clr_now) pre_nx = '0;
    pend_nx = pend_q;
    if (clr_fall_i)        pend_nx = 1'b1;
    else if (shift_rise_i) pend_nx = 1'b0;
  end

  assign chain_in_o = clr_now ? cell_t'('0) : pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      pre_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      sh_q   <= sh_nx;
      pre_q  <= pre_nx;
      pend_q <= pend_nx;
    end
  end
endmodule

// File: rtl/slp_out_chain.sv
module slp_out_chain
  import slp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  cell_t            in_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] valid_o
);
  cell_t stage_q [WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    cell_t src;
    if (i == 0) begin : g_head
      assign src = in_i;
    end else begin : g_body
      assign src = stage_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[i] <= '0;
      else if (adv_i) stage_q[i] <= src;
    end
    assign data_o[i]  = stage_q[i].data;
    assign valid_o[i] = stage_q[i].valid;
  end
endmodule

// File: rtl/slp_latch.sv
module slp_latch
  import slp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic             shift_stb_i,
  input  logic             store_stb_i,
  input  logic             clr_ni,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_valid_o
);
  logic  shift_rise, store_rise, clr_fall;
  logic  unused_shift_fall, unused_store_fall, unused_clr_rise;
  logic [WIDTH-1:0] q_raw;
  cell_t chain_in;

  slp_edge_det u_shift_ed (
    .clk_i, .rst_ni, .sig_i(shift_stb_i), .idle_i(1'b0),
    .rise_o(shift_rise), .fall_o(unused_shift_fall)
  );
  slp_edge_det u_store_ed (
    .clk_i, .rst_ni, .sig_i(store_stb_i), .idle_i(1'b0),
    .rise_o(store_rise), .fall_o(unused_store_fall)
  );
  slp_edge_det u_clr_ed (
    .clk_i, .rst_ni, .sig_i(clr_ni), .idle_i(1'b1),
    .rise_o(unused_clr_rise), .fall_o(clr_fall)
  );

  slp_front u_front (
    .clk_i, .rst_ni, .data_i,
    .shift_rise_i(shift_rise), .store_rise_i(store_rise),
    .clr_fall_i(clr_fall), .chain_in_o(chain_in)
  );

  slp_out_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i, .rst_ni, .adv_i(store_rise), .in_i(chain_in),
    .data_o(q_raw), .valid_o(q_valid_o)
  );

  assign q_o = oe_ni ? '0 : q_raw;
endmodule

// File: rtl/slp_latch_chk.sv
module slp_latch_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shift_stb_i,
  input logic             store_stb_i,
  input logic             clr_ni,
  input logic             oe_ni,
  input logic [WIDTH-1:0] q_o,
  input logic [WIDTH-1:0] q_valid_o
);
  logic sh_p, st_p, clr_p, pend;
  logic sh_r, st_r, clr_f;

  assign sh_r  = shift_stb_i & ~sh_p;
  assign st_r  = store_stb_i & ~st_p;
  assign clr_f = ~clr_ni & clr_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_p <= 1'b0; st_p <= 1'b0; clr_p <= 1'b1; pend <= 1'b0;
    end else begin
      sh_p <= shift_stb_i; st_p <= store_stb_i; clr_p <= clr_ni;
      if (clr_f)     pend <= 1'b1;
      else if (sh_r) pend <= 1'b0;
    end
  end

  assert_invalid_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & ~q_valid_o) == '0);

  assert_valid_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_r |=> q_valid_o[WIDTH-1:1] == $past(q_valid_o[WIDTH-2:0]));

  assert_data_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_r && !oe_ni) |=> (oe_ni || q_o[WIDTH-1:1] == $past(q_o[WIDTH-2:0])));

  assert_valid_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_r |=> $stable(q_valid_o));

  assert_data_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_r && !oe_ni) |=> (oe_ni || $stable(q_o)));

  assert_clear_head_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && sh_r && st_r) |=> !q_valid_o[0]);
endmodule

bind slp_latch slp_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .shift_stb_i(shift_stb_i),
  .store_stb_i(store_stb_i), .clr_ni(clr_ni), .oe_ni(oe_ni),
  .q_o(q_o), .q_valid_o(q_valid_o)
);

// File: tb/tb_slp_latch.sv
module tb_slp_latch;
  localparam int W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic data_i = 1'b0, shift_stb_i = 1'b0, store_stb_i = 1'b0;
  logic clr_ni = 1'b1, oe_ni = 1'b0;
  logic [W-1:0] q_o, q_valid_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [W-1:0] mq = '0, mv = '0;
  logic msh = 0, mshv = 0, mpre = 0, mprev = 0, mpend = 0;

  always #10 clk = ~clk;

  slp_latch #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni, .data_i, .shift_stb_i, .store_stb_i,
    .clr_ni, .oe_ni, .q_o, .q_valid_o
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " data"}, q_o, oe_ni ? '0 : mq);
    chk({tag, " valid"}, q_valid_o, mv);
  endtask

  task automatic model_step(bit sh, bit st, logic d);
    logic in_d, in_v, nsh, nshv;
    bit clr_now;
    clr_now = mpend && sh;
    in_d = clr_now ? 1'b0 : mpre;
    in_v = clr_now ? 1'b0 : mprev;
    nsh  = sh ? d : msh;
    nshv = sh ? 1'b1 : mshv;
    if (st) begin
      mq = {mq[W-2:0], in_d};
      mv = {mv[W-2:0], in_v};
      mpre = nsh; mprev = nshv;
    end else if (clr_now) begin
      mpre = 1'b0; mprev = 1'b0;
    end
    msh = nsh; mshv = nshv;
    if (sh) mpend = 0;
  endtask

  task automatic strobe(bit sh, bit st, logic d, int hold = 1);
    @(negedge clk);
    data_i = d; shift_stb_i = sh; store_stb_i = st;
    repeat (hold) @(negedge clk);
    shift_stb_i = 0; store_stb_i = 0;
    model_step(sh, st, d);
  endtask

  task automatic do_clear();
    @(negedge clk); clr_ni = 0;
    @(negedge clk); clr_ni = 1;
    mpend = 1;
  endtask

  // expected word after WIDTH+1 combined strobes of bits w[W-1] first
  function automatic logic [W-1:0] full_word(logic [W-1:0] w);
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] word;
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    chk("R1 reset data", q_o, '0);
    chk("R1 reset valid", q_valid_o, '0);
    rst_ni = 1;
    @(negedge clk);

    // R2/R3: first word, MSB-first bit order into the stream
    word = 8'b1011_0010;
    for (int k = 1; k <= W; k++) begin
      strobe(1, 1, word[W-k]);
      chk_all("R2 lag");
    end
    chk("R3 top unset", {7'd0, q_valid_o[W-1]}, 8'd0);
    strobe(1, 1, 1'b1);
    chk("R3 full word", q_o, full_word(word));
    chk("R3 all valid", q_valid_o, '1);

    // R4: clear armed, outputs untouched
    do_clear();
    repeat (3) @(negedge clk);
    chk("R4 data held", q_o, word);
    chk_all("R4 held");

    // R5/R6: next transfer after clear
    word = 8'b0110_1101;
    strobe(1, 1, word[W-1]);
    chk("R5 head cleared", {q_o[0], q_valid_o[0]}, 8'd0);
    chk_all("R5 step");
    for (int k = 2; k <= W; k++) begin
      strobe(1, 1, word[W-k]);
      chk_all("R6 step");
    end
    strobe(1, 1, 1'b0);
    chk("R6 new word", q_o, word);
    chk("R6 all valid", q_valid_o, '1);

    // R7: output enable
    @(negedge clk); oe_ni = 1;
    @(negedge clk);
    chk("R7 disabled", q_o, '0);
    chk("R7 valid kept", q_valid_o, '1);
    strobe(1, 1, 1'b1);
    chk_all("R7 strobe while off");
    @(negedge clk); oe_ni = 0;
    @(negedge clk);
    chk_all("R7 restored");

    // R8: held strobe acts once
    strobe(1, 1, 1'b0, 4);
    chk_all("R8 held strobe");

    // R9: split strobes
    strobe(1, 0, 1'b1);
    chk_all("R9 shift only");
    strobe(0, 1, 1'b0);
    chk_all("R9 store one");
    strobe(0, 1, 1'b0);
    chk("R9 shifted bit", {7'd0, q_o[0]}, 8'd1);
    chk_all("R9 store two");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5)       strobe(1, 1, 1'($urandom_range(0, 1)));
      else if (op == 5) strobe(1, 0, 1'($urandom_range(0, 1)));
      else if (op == 6) strobe(0, 1, 1'b0);
      else if (op == 7) do_clear();
      else begin
        @(negedge clk); oe_ni = 1'($urandom_range(0, 1));
      end
      @(negedge clk);
      chk_all("R2 R5 R7 R9 random");
      chk("R1 invalid zero", q_o & ~q_valid_o, '0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule